// File: doc/BRIEF.md
# Bus Cycle Watchdog Timer

This block guards every I/O or memory bus cycle against a ready that never comes. When a cycle opens, it arms a timer that counts rising edges of a separate, slower timing clock. If the external ready (active low) has not shown up by the second such edge, the block raises a ready-override so that the core's internal ready can be forced low and the stalled cycle closes. In the same system-clock cycle it emits a one-clock fault strobe on one of two lines. One line is for I/O cycles and the other is for memory cycles.

The timing clock is not used as a clock. It is synchronised into the system clock domain and its rising edges become single-cycle ticks, so the timeout window lies between one and two timing-clock periods plus a small synchronisation delay. While the DMA pause input or the hold acknowledge input is low, the timer is cleared and kept idle. If a bus cycle is still open when both are released, the timer re-arms with a fresh count. Fault capture and interrupt generation are handled downstream.

Top module: `bus_watchdog`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, force_rdy_o, flt_io_o and flt_mem_o are all 0.
- R2: A bus cycle (cyc_i high) in which ext_rdy_ni goes low before the timer expires produces no override and no fault strobe.
- R3: The timer expires on the second timing tick counted after the cycle opened. A tick is one rising edge of tclk_i, seen two system clocks late through the synchroniser. On expiry, force_rdy_o and the fault strobe rise on the next clock edge.
- R4: A timeout raises flt_io_o when io_sel_i is 1 (I/O cycle) and flt_mem_o when io_sel_i is 0 (memory cycle). The two are never high together.
- R5: A fault strobe lasts exactly one system clock.
- R6: Once raised, force_rdy_o stays high while cyc_i stays high and the timer is enabled. It falls on the first clock edge after cyc_i goes low.
- R7: If ext_rdy_ni is low in the cycle where the expiring tick is counted, the ready wins: no override and no fault.
- R8: While pause_ni or hold_ack_ni is low, the timer is cleared. force_rdy_o drops on the next edge and no fault strobe is produced. After release, an open cycle re-arms with a fresh count.
- R9: At most one fault strobe is produced per bus cycle, however long the cycle is held.
- R10: Only rising edges of tclk_i advance the timer. A timing clock held at a constant level never causes a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tclk_i | input | 1 | Timing clock, sampled as data |
| cyc_i | input | 1 | High for the duration of a bus cycle |
| io_sel_i | input | 1 | 1 = I/O cycle, 0 = memory cycle; stable during a cycle |
| ext_rdy_ni | input | 1 | External ready, active low |
| pause_ni | input | 1 | DMA pause, active low; clears and disables the timer |
| hold_ack_ni | input | 1 | Hold acknowledge, active low; clears and disables the timer |
| force_rdy_o | output | 1 | Ready override after a timeout |
| flt_io_o | output | 1 | One-clock timeout strobe for an I/O cycle |
| flt_mem_o | output | 1 | One-clock timeout strobe for a memory cycle |

## Verification
The assertions assume that io_sel_i stays constant for the whole time cyc_i is high, and that each cycle is separated from the next by at least one clock with cyc_i low. They also assume that tclk_i is slow compared with the system clock. The stimulus drives every input at the falling edge of clk_i, and holds io_sel_i fixed inside each cycle task. It drops cyc_i for several clocks between cycles and derives tclk_i from a divider of at least eight system clocks. Ready is placed relative to the timing ticks, including the exact cycle of expiry, so that the race case is hit on purpose.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FORCE = 2'd2,
    ST_DONE  = 2'd3
  } bwd_state_e;
endpackage

// File: rtl/bwd_tick_sync.sv
module bwd_tick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tclk_i,
  output logic tick_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= tclk_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];
  end

  // rising edge of the synchronised timing clock
  assign tick_o = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/bwd_timer.sv
module bwd_timer
  import bwd_pkg::*;
#(
  parameter int unsigned EXPIRE_EDGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       cyc_i,
  input  logic       rdy_ni,
  input  logic       tick_i,
  output logic       expire_o,
  output bwd_state_e state_o
);
  localparam int unsigned CNT_W = $clog2(EXPIRE_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EXPIRE_EDGES - 1);

  bwd_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (!en_i || !cyc_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_d   = '0;
          state_d = rdy_ni ? ST_RUN : ST_DONE;
        end
        ST_RUN: begin
          if (!rdy_ni) begin
            state_d = ST_DONE;  // ready beats a same-cycle expiry
          end else if (tick_i) begin
            if (cnt_q == CNT_LAST) begin
              state_d  = ST_FORCE;
              expire_o = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_FORCE: state_d = ST_FORCE;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/bwd_fault_out.sv
module bwd_fault_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic io_sel_i,
  output logic flt_io_o,
  output logic flt_mem_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_io_o  <= 1'b0;
      flt_mem_o <= 1'b0;
    end else begin
      flt_io_o  <= expire_i &  io_sel_i;
      flt_mem_o <= expire_i & ~io_sel_i;
    end
  end
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
  import bwd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned EXPIRE_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tclk_i,
  input  logic cyc_i,
  input  logic io_sel_i,
  input  logic ext_rdy_ni,
  input  logic pause_ni,
  input  logic hold_ack_ni,
  output logic force_rdy_o,
  output logic flt_io_o,
  output logic flt_mem_o
);
  logic       tick;
  logic       expire;
  logic       timer_en;
  bwd_state_e state;

  assign timer_en = pause_ni & hold_ack_ni;

  bwd_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tclk_i (tclk_i),
    .tick_o (tick)
  );

  bwd_timer #(.EXPIRE_EDGES(EXPIRE_EDGES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (timer_en),
    .cyc_i    (cyc_i),
    .rdy_ni   (ext_rdy_ni),
    .tick_i   (tick),
    .expire_o (expire),
    .state_o  (state)
  );

  bwd_fault_out u_fault (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .io_sel_i  (io_sel_i),
    .flt_io_o  (flt_io_o),
    .flt_mem_o (flt_mem_o)
  );

  assign force_rdy_o = (state == ST_FORCE);
endmodule

// File: rtl/bus_watchdog_chk.sv
module bus_watchdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tclk_i,
  input logic cyc_i,
  input logic io_sel_i,
  input logic ext_rdy_ni,
  input logic pause_ni,
  input logic hold_ack_ni,
  input logic force_rdy_o,
  input logic flt_io_o,
  input logic flt_mem_o
);
  // R4
  one_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flt_io_o && flt_mem_o));

  // R5
  io_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_io_o |=> !flt_io_o);

  // R5
  mem_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_mem_o |=> !flt_mem_o);

  // R3
  fault_with_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_io_o || flt_mem_o) |-> force_rdy_o);

  // R6
  force_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_rdy_o && cyc_i && pause_ni && hold_ack_ni) |=> force_rdy_o);

  // R6
  force_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_i |=> !force_rdy_o);

  // R8
  disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pause_ni || !hold_ack_ni) |=> !(force_rdy_o || flt_io_o || flt_mem_o));

  // R7
  ready_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_rdy_ni && !force_rdy_o) |=> !(flt_io_o || flt_mem_o));
endmodule

bind bus_watchdog bus_watchdog_chk u_chk (.*);

// File: tb/bus_watchdog_bench.sv
module bus_watchdog_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tclk = 1'b0;
  logic cyc = 1'b0, io_sel = 1'b0, rdy_n = 1'b1, pause_n = 1'b1, hold_n = 1'b1;
  logic force_rdy, flt_io, flt_mem;

  int errors = 0;
  int checks = 0;
  int n_io = 0, n_mem = 0;
  int tclk_half = 4;
  bit tclk_run = 1'b1;
  int tclk_cnt = 0;
  int cyc_cnt = 0;

  // reference model state
  bit q_t[$];
  int m_mode = 0;  // 0 idle, 1 counting, 2 forced, 3 finished
  int m_edges = 0;
  bit m_force = 0, m_fio = 0, m_fmem = 0;

  always #2 clk = ~clk;  // 250 MHz

  bus_watchdog u_bus_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .tclk_i(tclk), .cyc_i(cyc), .io_sel_i(io_sel),
    .ext_rdy_ni(rdy_n), .pause_ni(pause_n), .hold_ack_ni(hold_n),
    .force_rdy_o(force_rdy), .flt_io_o(flt_io), .flt_mem_o(flt_mem)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit pending_tick();
    return q_t[1] && !q_t[2];
  endfunction

  // timing clock generator
  always @(negedge clk) begin
    if (tclk_run) begin
      tclk_cnt++;
      if (tclk_cnt >= tclk_half) begin
        tclk_cnt = 0;
        tclk = ~tclk;
      end
    end
  end

  // behavioural reference: tick = tclk rise seen two samples late
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_t = {1'b0, 1'b0, 1'b0};
      m_mode = 0; m_edges = 0; m_force = 0; m_fio = 0; m_fmem = 0;
    end else begin
      bit tk;
      tk = pending_tick();
      q_t.push_front(tclk);
      void'(q_t.pop_back());
      m_fio = 0; m_fmem = 0;
      if (!pause_n || !hold_n || !cyc) begin
        m_mode = 0; m_edges = 0;
      end else if (m_mode == 0) begin
        m_edges = 0;
        m_mode = rdy_n ? 1 : 3;
      end else if (m_mode == 1) begin
        if (!rdy_n) m_mode = 3;
        else if (tk) begin
          m_edges++;
          if (m_edges == 2) begin
            m_mode = 2;
            if (io_sel) m_fio = 1; else m_fmem = 1;
          end
        end
      end
      m_force = (m_mode == 2);
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 R6", "force_rdy_o", force_rdy, m_force);
      chk("R4 R5", "flt_io_o", flt_io, m_fio);
      chk("R4 R5", "flt_mem_o", flt_mem, m_fmem);
      if (flt_io) n_io++;
      if (flt_mem) n_mem++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // open a cycle; rdy_at < 0 means no ready
  task automatic bus_cycle(input bit io, input int rdy_at, input int len);
    @(negedge clk);
    io_sel = io; cyc = 1'b1; rdy_n = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == rdy_at) rdy_n = 1'b0;
    end
    cyc = 1'b0; rdy_n = 1'b1;
    idle(4);
  endtask

  initial begin
    // R1 reset state
    idle(3);
    chk("R1", "force in reset", force_rdy, 0);
    chk("R1", "flt_io in reset", flt_io, 0);
    chk("R1", "flt_mem in reset", flt_mem, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", int'({force_rdy, flt_io, flt_mem}), 0);
    idle(10);

    // R2 early ready
    n_io = 0; n_mem = 0;
    bus_cycle(1'b0, 3, 20);
    bus_cycle(1'b1, 5, 12);
    chk("R2", "faults with early ready", n_io + n_mem, 0);

    // R3 R4 R6 I/O timeout, override held until cycle ends
    n_io = 0; n_mem = 0;
    @(negedge clk);
    io_sel = 1'b1; cyc = 1'b1;
    begin
      int dly = 0;
      while (!force_rdy && dly < 100) begin @(negedge clk); dly++; end
      chk("R3", "expiry inside window", int'(dly >= 8 && dly <= 21), 1);
    end
    idle(15);
    chk("R6", "override held while cycle open", force_rdy, 1);
    cyc = 1'b0;
    @(negedge clk);
    chk("R6", "override dropped after cycle", force_rdy, 0);
    idle(4);
    chk("R4", "I/O timeout flag count", n_io, 1);
    chk("R4", "no memory flag on I/O", n_mem, 0);

    // R4 memory timeout
    n_io = 0; n_mem = 0;
    bus_cycle(1'b0, -1, 30);
    chk("R4", "memory timeout flag count", n_mem, 1);
    chk("R4", "no I/O flag on memory", n_io, 0);

    // R9 one strobe for a very long cycle
    n_io = 0; n_mem = 0;
    bus_cycle(1'b1, -1, 90);
    chk("R9", "single strobe for long cycle", n_io, 1);

    // R7 ready in the expiry cycle
    n_io = 0; n_mem = 0;
    @(negedge clk);
    io_sel = 1'b1; cyc = 1'b1;
    begin
      int w = 0;
      while (!(m_mode == 1 && m_edges == 1 && pending_tick()) && w < 100) begin
        @(negedge clk); w++;
      end
      rdy_n = 1'b0;
    end
    idle(25);
    cyc = 1'b0; rdy_n = 1'b1;
    idle(4);
    chk("R7", "ready wins over expiry", n_io + n_mem, 0);

    // R8 pause over whole cycle
    n_io = 0; n_mem = 0;
    pause_n = 1'b0;
    bus_cycle(1'b1, -1, 40);
    pause_n = 1'b1;
    chk("R8", "no strobe under pause", n_io + n_mem, 0);

    // R8 hold during forced state, then re-arm
    n_io = 0; n_mem = 0;
    @(negedge clk);
    io_sel = 1'b0; cyc = 1'b1;
    begin
      int w = 0;
      while (!force_rdy && w < 100) begin @(negedge clk); w++; end
    end
    hold_n = 1'b0;
    @(negedge clk);
    chk("R8", "override cleared by hold", force_rdy, 0);
    idle(10);
    hold_n = 1'b1;
    idle(30);
    chk("R8", "re-armed after hold", force_rdy, 1);
    cyc = 1'b0;
    idle(4);
    chk("R8", "strobes before and after hold", n_mem, 2);

    // R10 stopped timing clock
    n_io = 0; n_mem = 0;
    tclk_run = 1'b0;
    bus_cycle(1'b1, -1, 100);
    chk("R10", "no timeout with stopped timing clock", n_io + n_mem, 0);

    // R10 slow timing clock, ready within one period
    tclk_half = 20; tclk_cnt = 0; tclk_run = 1'b1;
    idle(50);
    bus_cycle(1'b0, 25, 40);
    chk("R10", "slow clock single tick only", n_io + n_mem, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cyc_cnt < 50000) begin @(posedge clk); cyc_cnt++; end
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule